// File: doc/BRIEF.md
# Exception Entry State Updater

This block owns the privileged control registers that a simple in-order core changes when it takes a synchronous exception or an interrupt: the status word, the cause word, the exception return address, the faulting virtual address and the shadow register set control word. When the pipeline presents an exception strobe with its 5-bit code, the faulting PC, the following PC and, when they apply, a coprocessor number and a bad address, the block commits every change in that one clock edge. The changes are: the exception level flag is set, the cause is recorded, delay-slot placement is detected from the PC pair, and the shadow sets rotate when the core was neither at exception level nor in bootstrap mode.

All five registers can also be written through a plain write port that selects one register at a time. Every register is visible on its own output at all times. Handler address generation, translation lookups and pipeline flushing belong to other blocks. The exception strobe is a single-cycle pulse, and the block accepts one on every cycle without back-pressure.

Top module: `exc_entry_state`

## Requirements
- R1: After reset, status_o holds only bit 29 (coprocessor-1 usable) set. cause_o, epc_o, badvaddr_o and shadow_o are all zero.
- R2: A strobe on exc_valid_i sets status bit 1 (exception level) on the next edge, even when it is already set. All other status bits are kept.
- R3: If exc_npc_i differs from exc_pc_i + 4 (modulo 2^32), the faulting instruction sits in a delay slot. In that case epc_o takes exc_pc_i - 4 and cause bit 31 is set to 1. Otherwise epc_o takes exc_pc_i and cause bit 31 is cleared. Both results are visible in the cycle after the strobe.
- R4: Cause bits [6:2] take exc_code_i (interrupt 0, TLB modified 1, TLB load 2, TLB store 3, address error load 4, address error store 5, syscall 8, breakpoint 9, reserved instruction 10, coprocessor unusable 11, overflow 12, trap 13). Cause bits other than [6:2], [29:28] and 31 are kept.
- R5: Cause bits [29:28] take exc_cop_i when the code is 11, and are cleared for every other code.
- R6: badvaddr_o captures exc_badva_i for codes 1 to 5. It is unchanged for every other code.
- R7: The shadow word holds the current set in [3:0], the previous set in [7:4] and the exception set in [11:8]. If status bit 1 and status bit 22 (bootstrap) were both 0 before the strobe, the previous set takes the old current set and the current set takes the exception set. If either bit was 1, the shadow word is unchanged.
- R8: With no exception pending, wr_en_i writes wr_data_i on the next edge into the register chosen by wr_sel_i: 0 status, 1 cause, 2 epc, 3 badvaddr, 4 shadow (low 12 bits). Other select values change nothing.
- R9: A write presented in the same cycle as an exception strobe is discarded, including a write to a register the exception does not touch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exc_valid_i | input | 1 | Exception taken this cycle |
| exc_code_i | input | 5 | Exception code |
| exc_pc_i | input | 32 | PC of the faulting instruction |
| exc_npc_i | input | 32 | PC that would follow it |
| exc_cop_i | input | 2 | Coprocessor number for code 11 |
| exc_badva_i | input | 32 | Faulting virtual address |
| wr_en_i | input | 1 | Register write enable |
| wr_sel_i | input | 3 | Register select for the write |
| wr_data_i | input | 32 | Write data |
| status_o | output | 32 | Status register |
| cause_o | output | 32 | Cause register |
| epc_o | output | 32 | Exception return address |
| badvaddr_o | output | 32 | Faulting address register |
| shadow_o | output | 12 | Shadow set control word |

## Verification
On every cycle after a strobe, the assertions check the following. The level flag is set and the other status bits are kept. The code field matches the strobe's code. The coprocessor field is clear for codes other than 11. The faulting address is stable for codes outside 1 to 5. The delay-slot bit agrees with whether the saved return address differs from the faulting PC. The shadow word either rotates or holds, depending on the previous level and bootstrap flags. Only the bench scenarios show the exact return address for given PC pairs, including the wrap at the top of the address space. They also show the reset values, the write port selects, and that a write racing an exception is discarded.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int XLEN   = 32;
  localparam int SET_W  = 4;

  localparam int ST_EXL = 1;
  localparam int ST_BEV = 22;
  localparam int ST_CU1 = 29;

  localparam int CA_CODE_LO = 2;
  localparam int CA_CODE_HI = 6;
  localparam int CA_CE_LO   = 28;
  localparam int CA_CE_HI   = 29;
  localparam int CA_BD      = 31;

  typedef enum logic [2:0] {
    SEL_STATUS = 3'd0,
    SEL_CAUSE  = 3'd1,
    SEL_EPC    = 3'd2,
    SEL_BADVA  = 3'd3,
    SEL_SHADOW = 3'd4
  } reg_sel_e;

  typedef enum logic [4:0] {
    EC_INT     = 5'd0,
    EC_TLB_MOD = 5'd1,
    EC_TLB_LD  = 5'd2,
    EC_TLB_ST  = 5'd3,
    EC_ADE_LD  = 5'd4,
    EC_ADE_ST  = 5'd5,
    EC_SYS     = 5'd8,
    EC_BRK     = 5'd9,
    EC_RSVD    = 5'd10,
    EC_CPU     = 5'd11,
    EC_OVF     = 5'd12,
    EC_TRAP    = 5'd13
  } exc_code_e;

  function automatic logic captures_addr(input logic [4:0] code);
    return (code >= EC_TLB_MOD) && (code <= EC_ADE_ST);
  endfunction
endpackage

// File: rtl/exc_epc_unit.sv
module exc_epc_unit #(
  parameter int AW         = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] npc_i,
  output logic [AW-1:0] epc_o,
  output logic          in_slot_o
);
  localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

  logic [AW-1:0] seq_pc;

  always_comb begin
    seq_pc    = pc_i + STEP;
    in_slot_o = (seq_pc != npc_i);
    epc_o     = in_slot_o ? (pc_i - STEP) : pc_i;
  end
endmodule

// File: rtl/exc_cause_unit.sv
module exc_cause_unit
  import exc_entry_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] cause_i,
  input  logic [4:0]    code_i,
  input  logic [1:0]    cop_i,
  input  logic          in_slot_i,
  output logic [DW-1:0] cause_o
);
  always_comb begin
    cause_o = cause_i;
    cause_o[CA_CODE_HI:CA_CODE_LO] = code_i;
    cause_o[CA_CE_HI:CA_CE_LO]     = (code_i == EC_CPU) ? cop_i : 2'b00;
    cause_o[CA_BD]                 = in_slot_i;
  end
endmodule

// File: rtl/exc_shadow_unit.sv
module exc_shadow_unit #(
  parameter int SW = 4,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          exc_i,
  input  logic          rotate_ok_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [3*SW-1:0] shadow_o
);
  localparam int WW = 3 * SW;

  logic [SW-1:0] cur_q, prev_q, ess_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      prev_q <= '0;
      ess_q  <= '0;
    end else if (exc_i) begin
      if (rotate_ok_i) begin
        prev_q <= cur_q;
        cur_q  <= ess_q;
      end
    end else if (wr_i) begin
      cur_q  <= wr_data_i[SW-1:0];
      prev_q <= wr_data_i[2*SW-1:SW];
      ess_q  <= wr_data_i[WW-1:2*SW];
    end
  end

  assign shadow_o = {ess_q, prev_q, cur_q};

  a_r7_rotate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i && rotate_ok_i |=> (shadow_o[2*SW-1:SW] == $past(shadow_o[SW-1:0]))
                           && (shadow_o[SW-1:0] == $past(shadow_o[WW-1:2*SW])));
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i && !rotate_ok_i |=> $stable(shadow_o));
endmodule

// File: rtl/exc_entry_state.sv
module exc_entry_state
  import exc_entry_pkg::*;
#(
  parameter int AW         = 32,
  parameter int SW         = 4,
  parameter int INSN_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exc_valid_i,
  input  logic [4:0]        exc_code_i,
  input  logic [AW-1:0]     exc_pc_i,
  input  logic [AW-1:0]     exc_npc_i,
  input  logic [1:0]        exc_cop_i,
  input  logic [AW-1:0]     exc_badva_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [AW-1:0]     wr_data_i,
  output logic [AW-1:0]     status_o,
  output logic [AW-1:0]     cause_o,
  output logic [AW-1:0]     epc_o,
  output logic [AW-1:0]     badvaddr_o,
  output logic [3*SW-1:0]   shadow_o
);
  localparam logic [AW-1:0] STATUS_RST = AW'(1) << ST_CU1;
  localparam logic [AW-1:0] EXL_MASK   = AW'(1) << ST_EXL;

  logic [AW-1:0] status_q, cause_q, epc_q, bva_q;
  logic [AW-1:0] epc_next, cause_next;
  logic          in_slot;
  logic          sw_wr;
  logic          rotate_ok;

  // Software writes are dropped outright when an exception commits.
  assign sw_wr     = wr_en_i && !exc_valid_i;
  assign rotate_ok = !status_q[ST_EXL] && !status_q[ST_BEV];

  exc_epc_unit #(.AW(AW), .INSN_BYTES(INSN_BYTES)) epc_u (
    .pc_i      (exc_pc_i),
    .npc_i     (exc_npc_i),
    .epc_o     (epc_next),
    .in_slot_o (in_slot)
  );

  exc_cause_unit #(.DW(AW)) cause_u (
    .cause_i   (cause_q),
    .code_i    (exc_code_i),
    .cop_i     (exc_cop_i),
    .in_slot_i (in_slot),
    .cause_o   (cause_next)
  );

  exc_shadow_unit #(.SW(SW), .DW(AW)) shadow_u (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .exc_i       (exc_valid_i),
    .rotate_ok_i (rotate_ok),
    .wr_i        (sw_wr && (wr_sel_i == SEL_SHADOW)),
    .wr_data_i   (wr_data_i),
    .shadow_o    (shadow_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= STATUS_RST;
      cause_q  <= '0;
      epc_q    <= '0;
      bva_q    <= '0;
    end else if (exc_valid_i) begin
      status_q <= status_q | EXL_MASK;
      cause_q  <= cause_next;
      epc_q    <= epc_next;
      if (captures_addr(exc_code_i)) bva_q <= exc_badva_i;
    end else if (sw_wr) begin
      case (wr_sel_i)
        SEL_STATUS: status_q <= wr_data_i;
        SEL_CAUSE:  cause_q  <= wr_data_i;
        SEL_EPC:    epc_q    <= wr_data_i;
        SEL_BADVA:  bva_q    <= wr_data_i;
        default: ;
      endcase
    end
  end

  assign status_o   = status_q;
  assign cause_o    = cause_q;
  assign epc_o      = epc_q;
  assign badvaddr_o = bva_q;

  a_r2_exl_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i |=> status_o[ST_EXL]);
  a_r2_status_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i |=> ((status_o | EXL_MASK) == ($past(status_o) | EXL_MASK)));
  a_r3_bd_epc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i |=> (cause_o[CA_BD] == (epc_o != $past(exc_pc_i))));
  a_r4_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i |=> (cause_o[CA_CODE_HI:CA_CODE_LO] == $past(exc_code_i)));
  a_r5_ce_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i && (exc_code_i != EC_CPU) |=> (cause_o[CA_CE_HI:CA_CE_LO] == 2'b00));
  a_r6_bva_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i && !captures_addr(exc_code_i) |=> $stable(badvaddr_o));
endmodule

// File: tb/exc_entry_state_tb_top.sv
`timescale 1ns/1ps
module exc_entry_state_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        exc_valid = 0;
  logic [4:0]  exc_code = '0;
  logic [31:0] exc_pc = '0, exc_npc = '0, exc_badva = '0;
  logic [1:0]  exc_cop = '0;
  logic        wr_en = 0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] status, cause, epc, bva;
  logic [11:0] shadow;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  exc_entry_state dut_i (
    .clk_i(clk), .rst_ni(rst_n), .exc_valid_i(exc_valid), .exc_code_i(exc_code),
    .exc_pc_i(exc_pc), .exc_npc_i(exc_npc), .exc_cop_i(exc_cop), .exc_badva_i(exc_badva),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .status_o(status), .cause_o(cause), .epc_o(epc), .badvaddr_o(bva), .shadow_o(shadow)
  );

  localparam int NV = 8;
  localparam logic [31:0] V_PC [NV] = '{32'h1000, 32'h2004, 32'h0, 32'h10,
                                        32'h100, 32'hFFFF_FFFC, 32'h4, 32'h8000};
  localparam logic [31:0] V_NPC[NV] = '{32'h1004, 32'h3000, 32'h4, 32'h40,
                                        32'h104, 32'h0, 32'h4, 32'h7000};
  localparam logic [4:0]  V_CODE[NV] = '{5'd8, 5'd12, 5'd9, 5'd11, 5'd11, 5'd13, 5'd4, 5'd0};
  localparam logic [1:0]  V_COP [NV] = '{2'd1, 2'd0, 2'd3, 2'd2, 2'd3, 2'd1, 2'd0, 2'd2};
  localparam logic [31:0] V_EPC [NV] = '{32'h1000, 32'h2000, 32'h0, 32'hC,
                                        32'h100, 32'hFFFF_FFFC, 32'h0, 32'h7FFC};
  localparam logic        V_BD  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sw_write(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic take_exc(input logic [31:0] pc, input logic [31:0] npc,
                          input logic [4:0] code, input logic [1:0] cop,
                          input logic [31:0] badva);
    @(negedge clk);
    exc_valid = 1; exc_pc = pc; exc_npc = npc; exc_code = code;
    exc_cop = cop; exc_badva = badva;
    @(negedge clk);
    exc_valid = 0;
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] bva_model;
    logic [31:0] pre_shadow;
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 status", status, 32'h2000_0000);
    check("R1 cause", cause, 32'h0);
    check("R1 epc", epc, 32'h0);
    check("R1 badvaddr", bva, 32'h0);
    check("R1 shadow", {20'h0, shadow}, 32'h0);
    rst_n = 1;
    @(negedge clk);

    bva_model = 32'h0;
    for (int i = 0; i < NV; i++) begin
      logic [31:0] ba;
      logic [31:0] exp_cause;
      ba = 32'hBAD0_0000 + 32'(i);
      sw_write(3'd0, 32'h2000_0000);                   // clear level flag
      sw_write(3'd1, 32'h0000_A500);                   // bits that must be kept
      sw_write(3'd4, {20'h0, 4'(i + 3), 4'h0, 4'(i)});
      take_exc(V_PC[i], V_NPC[i], V_CODE[i], V_COP[i], ba);
      if (V_CODE[i] >= 5'd1 && V_CODE[i] <= 5'd5) bva_model = ba;
      exp_cause = 32'h0000_A500 | (32'(V_CODE[i]) << 2) | (32'(V_BD[i]) << 31)
                | ((V_CODE[i] == 5'd11) ? (32'(V_COP[i]) << 28) : 32'h0);
      check($sformatf("R3 epc v%0d", i), epc, V_EPC[i]);
      check($sformatf("R3 R4 R5 cause v%0d", i), cause, exp_cause);
      check($sformatf("R2 status v%0d", i), status, 32'h2000_0002);
      check($sformatf("R6 badvaddr v%0d", i), bva, bva_model);
      check($sformatf("R7 shadow v%0d", i), {20'h0, shadow},
            {20'h0, 4'(i + 3), 4'(i), 4'(i + 3)});
    end

    // R7 level flag already set: shadow holds, R2 flag stays set
    sw_write(3'd4, 32'h0000_0921);
    take_exc(32'h40, 32'h44, 5'd8, 2'd0, 32'h0);
    check("R7 hold when level set", {20'h0, shadow}, 32'h921);
    check("R2 level stays set", status, 32'h2000_0002);

    // R7 bootstrap set: shadow holds
    sw_write(3'd0, 32'h2040_0000);
    take_exc(32'h40, 32'h44, 5'd9, 2'd0, 32'h0);
    check("R7 hold when bootstrap", {20'h0, shadow}, 32'h921);
    check("R2 bootstrap kept", status, 32'h2040_0002);

    // R8 write port readback, unused select ignored
    sw_write(3'd2, 32'h1234_5678);
    check("R8 epc write", epc, 32'h1234_5678);
    sw_write(3'd3, 32'hCAFE_0000);
    check("R8 badvaddr write", bva, 32'hCAFE_0000);
    pre_shadow = {20'h0, shadow};
    sw_write(3'd6, 32'hFFFF_FFFF);
    check("R8 unused sel status", status, 32'h2040_0002);
    check("R8 unused sel epc", epc, 32'h1234_5678);
    check("R8 unused sel badvaddr", bva, 32'hCAFE_0000);
    check("R8 unused sel shadow", {20'h0, shadow}, pre_shadow);

    // R9 write racing an exception is discarded
    @(negedge clk);
    exc_valid = 1; exc_pc = 32'h500; exc_npc = 32'h504; exc_code = 5'd8;
    exc_cop = 2'd0; exc_badva = 32'h0;
    wr_en = 1; wr_sel = 3'd3; wr_data = 32'h7777_7777;
    @(negedge clk);
    exc_valid = 0; wr_en = 0;
    check("R9 untouched reg write dropped", bva, 32'hCAFE_0000);
    check("R9 epc from exception", epc, 32'h500);
    @(negedge clk);
    exc_valid = 1; exc_pc = 32'h600; exc_npc = 32'h604; exc_code = 5'd12;
    wr_en = 1; wr_sel = 3'd2; wr_data = 32'h9999_9999;
    @(negedge clk);
    exc_valid = 0; wr_en = 0;
    check("R9 epc write loses", epc, 32'h600);

    // R3 R4 random sequence against a model
    for (int k = 0; k < 40; k++) begin
      logic [31:0] pc, npc, e_epc;
      logic [4:0] code;
      logic slot;
      pc = $urandom() & 32'hFFFF_FFFC;
      slot = $urandom_range(0, 1) == 1;
      npc = slot ? (pc + 32'h0010_0000) : (pc + 32'd4);
      code = 5'($urandom_range(0, 13));
      e_epc = slot ? (pc - 32'd4) : pc;
      take_exc(pc, npc, code, 2'd0, 32'h0);
      check($sformatf("R3 random epc %0d", k), epc, e_epc);
      check($sformatf("R3 R4 random cause %0d", k), {cause[31], cause[6:2]},
            {slot, code});
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule